// File: doc/BRIEF.md
# Threshold-Gated Transmit FIFO Drain

This block sits between a 256-byte transmit FIFO and an Ethernet MAC. It pulls bytes from the FIFO's read port and hands them to the MAC over a valid/ready byte stream. Its purpose is to keep a frame's transfer to the MAC independent of how quickly the bus fills the FIFO. It therefore holds back the start of a new frame until the FIFO is completely full. There is one exception: a frame short enough that its end-of-frame byte is already in the FIFO may start at once.

Once a frame is under way, the block forwards bytes whenever the FIFO has data and the MAC accepts them. It stops after the byte tagged end-of-frame. It then waits for the MAC's completion strobe. On that strobe it latches the returned status bits into a transmit status register. It also raises a one-cycle write-back request that carries the same bits, so a descriptor engine can store them in the current buffer descriptor's status field.

Top module: `txd_drain_top`

## Requirements
- R1: After reset, `mac_valid`, `fifo_rd_en` and `wb_req` are low and `tx_status` is zero.
- R2: In the idle state, a FIFO level equal to the depth (256 by default) starts a frame. `mac_valid` follows the FIFO's non-empty state from the cycle after the edge at which the start condition was seen.
- R3: In the idle state, `eof_pending` high starts a frame even when the level is below the depth. With `eof_pending` low and the level below the depth, no frame starts and `mac_valid` stays low.
- R4: While a frame is being sent, `mac_valid` is high exactly when `fifo_level` is non-zero. `mac_data` and `mac_last` show the FIFO head byte and its end-of-frame tag. `fifo_rd_en` is high exactly when `mac_valid` and `mac_ready` are both high.
- R5: A transfer of a byte tagged end-of-frame ends the frame, so `mac_valid` is low from the next cycle. A transfer of an untagged byte keeps the frame going.
- R6: While a frame is in progress or awaiting completion, a start condition (full FIFO or `eof_pending`) has no effect, and `mac_valid` stays low during the completion wait.
- R7: A `mac_done` pulse during the completion wait loads `mac_status` into `tx_status`, visible from the next cycle. The block then returns to idle.
- R8: `wb_req` is high for exactly one cycle, in the cycle after the accepted `mac_done`. While it is high, `wb_status` equals the captured status.
- R9: A `mac_done` pulse outside the completion wait is ignored: `tx_status` keeps its value and `wb_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | 9 | Bytes currently held in the transmit FIFO |
| eof_pending | input | 1 | An end-of-frame byte has been written into the FIFO |
| fifo_rd_data | input | 8 | FIFO head byte |
| fifo_rd_eof | input | 1 | End-of-frame tag of the head byte |
| fifo_rd_en | output | 1 | Pops the head byte |
| mac_valid | output | 1 | Byte offered to the MAC |
| mac_ready | input | 1 | MAC accepts the offered byte |
| mac_data | output | 8 | Byte to the MAC |
| mac_last | output | 1 | Offered byte is the last of the frame |
| mac_done | input | 1 | MAC completion strobe |
| mac_status | input | 8 | Status bits returned by the MAC |
| tx_status | output | 8 | Transmit status register |
| wb_req | output | 1 | One-cycle descriptor status write-back request |
| wb_status | output | 8 | Status carried by the write-back request |

## Verification
The assertions guard the properties that hold on every cycle:
- every frame start is preceded by a valid start condition;
- no pop happens from an empty FIFO;
- a transferred last byte always leads into the completion wait;
- the write-back request is a single pulse that follows an accepted completion;
- the status register changes only together with that pulse.

Only the bench scenarios can show the rest: which combinations of level and pending end-of-frame actually start a frame, that start conditions arriving mid-frame are ignored, that a completion strobe in idle leaves the status untouched, and that the captured values match what the MAC reported.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [1:0] {
    TXD_IDLE = 2'd0,
    TXD_SEND = 2'd1,
    TXD_WAIT = 2'd2
  } txd_state_e;
endpackage

// File: rtl/txd_start_gate.sv
module txd_start_gate #(
  parameter int DEPTH = 256,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             eof_pending,
  output logic             start_ok
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic is_full;

  always_comb begin
    is_full  = (fifo_level == FULL_LVL);
    start_ok = is_full | eof_pending;
  end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_eof,
  input  logic              mac_ready,
  input  logic              mac_done,
  output logic              mac_valid,
  output logic [DATA_W-1:0] mac_data,
  output logic              mac_last,
  output logic              fifo_rd_en,
  output logic              done_accept
);
  txd_state_e st_q, st_d;
  logic       in_send;
  logic       xfer;

  always_comb begin
    in_send     = (st_q == TXD_SEND);
    mac_valid   = in_send & (fifo_level != '0);
    mac_data    = fifo_rd_data;
    mac_last    = fifo_rd_eof;
    xfer        = mac_valid & mac_ready;
    fifo_rd_en  = xfer;
    done_accept = (st_q == TXD_WAIT) & mac_done;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TXD_IDLE: if (start_ok) st_d = TXD_SEND;
      TXD_SEND: if (xfer && fifo_rd_eof) st_d = TXD_WAIT;
      TXD_WAIT: if (mac_done) st_d = TXD_IDLE;
      default:  st_d = TXD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TXD_IDLE;
    else        st_q <= st_d;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_send) |-> $past(start_ok)); // R2

  AST_LAST_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && mac_ready && mac_last) |=> (st_q == TXD_WAIT)); // R5

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TXD_WAIT) |-> !fifo_rd_en); // R6
endmodule

// File: rtl/txd_status_wb.sv
module txd_status_wb #(
  parameter int ST_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_accept,
  input  logic [ST_W-1:0] mac_status,
  output logic [ST_W-1:0] tx_status,
  output logic            wb_req,
  output logic [ST_W-1:0] wb_status
);
  logic [ST_W-1:0] stat_q, stat_d;
  logic            req_q, req_d;
  logic            stat_en;

  always_comb begin
    stat_en = done_accept;
    stat_d  = mac_status;
    req_d   = done_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign tx_status = stat_q;
  assign wb_status = stat_q;
  assign wb_req    = req_q;

  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req); // R8

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_status) |-> wb_req); // R9
endmodule

// File: rtl/txd_drain_top.sv
module txd_drain_top #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int ST_W   = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              eof_pending,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_eof,
  output logic              fifo_rd_en,
  output logic              mac_valid,
  input  logic              mac_ready,
  output logic [DATA_W-1:0] mac_data,
  output logic              mac_last,
  input  logic              mac_done,
  input  logic [ST_W-1:0]   mac_status,
  output logic [ST_W-1:0]   tx_status,
  output logic              wb_req,
  output logic [ST_W-1:0]   wb_status
);
  logic start_ok;
  logic done_accept;

  txd_start_gate #(.DEPTH(DEPTH)) u_gate (
    .fifo_level (fifo_level),
    .eof_pending(eof_pending),
    .start_ok   (start_ok)
  );

  txd_seq #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ok    (start_ok),
    .fifo_level  (fifo_level),
    .fifo_rd_data(fifo_rd_data),
    .fifo_rd_eof (fifo_rd_eof),
    .mac_ready   (mac_ready),
    .mac_done    (mac_done),
    .mac_valid   (mac_valid),
    .mac_data    (mac_data),
    .mac_last    (mac_last),
    .fifo_rd_en  (fifo_rd_en),
    .done_accept (done_accept)
  );

  txd_status_wb #(.ST_W(ST_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_accept(done_accept),
    .mac_status (mac_status),
    .tx_status  (tx_status),
    .wb_req     (wb_req),
    .wb_status  (wb_status)
  );

  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (fifo_level != '0)); // R4

  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> $past(mac_done)); // R7
endmodule

// File: tb/tb_txd_drain_top.sv
module tb_txd_drain_top;
  localparam int DEPTH = 256;
  localparam int NV    = 8;

  logic       clk;
  logic       rst_n;
  logic [8:0] fifo_level;
  logic       eof_pending;
  logic [7:0] fifo_rd_data;
  logic       fifo_rd_eof;
  logic       fifo_rd_en;
  logic       mac_valid;
  logic       mac_ready;
  logic [7:0] mac_data;
  logic       mac_last;
  logic       mac_done;
  logic [7:0] mac_status;
  logic [7:0] tx_status;
  logic       wb_req;
  logic [7:0] wb_status;

  int n_chk;
  int n_fail;
  bit finished;

  // {level[18:10], eof_pending[9], expect_start[8], status[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {9'd256, 1'b0, 1'b1, 8'h15},
    {9'd255, 1'b0, 1'b0, 8'h00},
    {9'd128, 1'b0, 1'b0, 8'h00},
    {9'd1,   1'b0, 1'b0, 8'h00},
    {9'd255, 1'b1, 1'b1, 8'h2a},
    {9'd1,   1'b1, 1'b1, 8'h3f},
    {9'd64,  1'b1, 1'b1, 8'h01},
    {9'd256, 1'b1, 1'b1, 8'h7f}
  };

  txd_drain_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .eof_pending(eof_pending),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_eof(fifo_rd_eof), .fifo_rd_en(fifo_rd_en),
    .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_data(mac_data),
    .mac_last(mac_last), .mac_done(mac_done), .mac_status(mac_status),
    .tx_status(tx_status), .wb_req(wb_req), .wb_status(wb_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; fifo_level = '0; eof_pending = 1'b0; fifo_rd_data = '0;
    fifo_rd_eof = 1'b0; mac_ready = 1'b0; mac_done = 1'b0; mac_status = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mac_valid", 32'(mac_valid), 0);
    chk("R1 wb_req", 32'(wb_req), 0);
    chk("R1 tx_status", 32'(tx_status), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 idle rd_en", 32'(fifo_rd_en), 0);

    // R9: completion strobe while idle is ignored
    mac_done = 1'b1; mac_status = 8'hee;
    tick();
    mac_done = 1'b0;
    chk("R9 wb_req", 32'(wb_req), 0);
    chk("R9 tx_status", 32'(tx_status), 0);

    // Vector walk over start conditions (R2, R3) with completion (R5..R8)
    for (int i = 0; i < NV; i++) begin
      fifo_level = VEC[i][18:10]; eof_pending = VEC[i][9];
      mac_ready = 1'b0; fifo_rd_eof = 1'b0; fifo_rd_data = 8'(i + 8'h40);
      tick();
      chk(VEC[i][9] ? "R3 start" : "R2 start", 32'(mac_valid), 32'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk("R4 data", 32'(mac_data), 32'(i + 8'h40));
        fifo_rd_eof = 1'b1; mac_ready = 1'b1; eof_pending = 1'b0;
        #0.1;
        chk("R4 last", 32'(mac_last), 1);
        chk("R4 rd_en", 32'(fifo_rd_en), 1);
        tick();
        fifo_rd_eof = 1'b0; mac_ready = 1'b0;
        fifo_level = 9'd256; eof_pending = 1'b1;
        tick();
        chk("R6 wait valid", 32'(mac_valid), 0);
        chk("R5 end", 32'(wb_req), 0);
        mac_done = 1'b1; mac_status = VEC[i][7:0];
        tick();
        mac_done = 1'b0; fifo_level = '0; eof_pending = 1'b0;
        chk("R7 tx_status", 32'(tx_status), 32'(VEC[i][7:0]));
        chk("R8 wb_req", 32'(wb_req), 1);
        chk("R8 wb_status", 32'(wb_status), 32'(VEC[i][7:0]));
        tick();
        chk("R8 pulse end", 32'(wb_req), 0);
      end else begin
        tick();
        chk("R3 no start", 32'(mac_valid), 0);
        fifo_level = '0;
      end
    end

    // Multi-byte frame with a stall (R4, R5)
    fifo_level = 9'd256; eof_pending = 1'b0; fifo_rd_data = 8'ha5; fifo_rd_eof = 1'b0;
    tick();
    mac_ready = 1'b1;
    #0.1;
    chk("R4 data a5", 32'(mac_data), 32'h a5);
    chk("R4 pop", 32'(fifo_rd_en), 1);
    tick();
    chk("R5 keep going", 32'(mac_valid), 1);
    fifo_level = '0;
    #0.1;
    chk("R4 empty valid", 32'(mac_valid), 0);
    chk("R4 empty rd_en", 32'(fifo_rd_en), 0);
    tick();
    fifo_level = 9'd5; fifo_rd_eof = 1'b1; fifo_rd_data = 8'h3c;
    #0.1;
    chk("R4 resume", 32'(mac_valid), 1);
    tick();
    mac_ready = 1'b0; fifo_rd_eof = 1'b0;
    chk("R5 stop after last", 32'(mac_valid), 0);
    // R9: status kept until a completion in the wait state
    chk("R9 hold status", 32'(tx_status), 32'h7f);
    mac_done = 1'b1; mac_status = 8'h99; fifo_level = '0;
    tick();
    mac_done = 1'b0;
    chk("R7 final status", 32'(tx_status), 32'h99);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule